// File: doc/BRIEF.md
# Row-Parallel Sum of Absolute Differences Engine

This block measures how closely two 16x16 macroblocks of unsigned 8-bit pixels match. This is the cost figure that motion estimation minimises. A control agent pulses `start_i` to open a new comparison. It then feeds the two blocks one row at a time, as a pair of 128-bit words, over a valid/ready handshake. In each accepted cycle all 16 pixel lanes do three steps in parallel. Each lane subtracts one pixel from the other and takes the magnitude of the difference. An adder tree then reduces the 16 magnitudes and adds them into a running total.

The sixteenth accepted row closes the comparison. The total stays on `sad_o`, and `done_o` pulses for one cycle. The block then stops taking rows and holds the total until the next start. A start that arrives mid-block discards the partial total and begins again.

Top module: `sad_row_engine`

## Requirements
- R1: After reset, `sad_o` is 0, `done_o` is 0 and `row_ready_o` is 0.
- R2: In the cycle after `start_i` is high, `sad_o` is 0 and `row_ready_o` is 1, whatever the state was before.
- R3: A row pair is consumed only at a clock edge where `row_valid_i` and `row_ready_o` are both 1. A cycle with `row_valid_i` low leaves `sad_o` unchanged.
- R4: Lane i of each row word occupies bits [8i+7:8i] and holds an unsigned pixel. An accepted row adds the sum over all 16 lanes of |a_i - b_i| to `sad_o`. The new total is visible in the cycle right after the accepting edge.
- R5: In the cycle after the sixteenth accepted row since the last start, `done_o` is 1 and `row_ready_o` is 0. In the following cycle `done_o` is 0 again.
- R6: Once a block is complete, `sad_o` holds its final value until the next start. Row words presented with `row_valid_i` high in that interval are not consumed and do not change `sad_o`.
- R7: The total does not wrap. The worst case, every pixel difference 255, gives exactly 65280.
- R8: A start during an unfinished block discards the partial total and resets the row count. A row presented in the same cycle as the start is not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Pulse that opens a new comparison |
| row_valid_i | input | 1 | Row pair on the data inputs is valid |
| row_ready_o | output | 1 | Engine will take a row pair this cycle |
| row_a_i | input | 128 | Row of the first block, 16 lanes of 8 bits |
| row_b_i | input | 128 | Row of the second block, 16 lanes of 8 bits |
| sad_o | output | 16 | Running, then final, sum of absolute differences |
| done_o | output | 1 | One-cycle pulse once the block is complete |

## Verification
The assertions take for granted that `start_i` is a clean synchronous level. They also take for granted that the pixel inputs are defined whenever `row_valid_i` is high. They do not require `row_valid_i` to be held while the engine is not ready, since such rows are simply not consumed. The stimulus drives all inputs just after the falling edge. It inserts random idle gaps between rows and draws pixels from a fixed-seed generator, so the run repeats exactly. It offers rows while the engine is idle only to show that they are not consumed. Directed cases add an all-equal pair, the extreme 0-versus-255 pattern, alternating lane polarity, and a restart with a row offered in the start cycle.

// File: rtl/sad_pkg.sv
// Shared sizing for the row-parallel SAD engine.
// Assumes unsigned pixels; widths are derived so no sum can wrap.
package sad_pkg;

    localparam int DEF_LANES = 16;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_ROWS  = 16;

    // Bits needed to hold the value n (n >= 1).
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Width of one row's reduced sum.
    function automatic int row_sum_width(input int lanes, input int pix_w);
        return bits_for(lanes * ((1 << pix_w) - 1));
    endfunction

    // Width of the block accumulator.
    function automatic int acc_width(input int rows, input int lanes, input int pix_w);
        return bits_for(rows * lanes * ((1 << pix_w) - 1));
    endfunction

endpackage

// File: rtl/sad_lane_absdiff.sv
// One pixel lane: magnitude of the difference of two unsigned pixels.
// Purely combinational; the result fits the pixel width.
module sad_lane_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] mag
);

    // Subtract the smaller operand from the larger one.
    always_comb begin
        if (pix_a >= pix_b) begin
            mag = pix_a - pix_b;
        end else begin
            mag = pix_b - pix_a;
        end
    end

endmodule

// File: rtl/sad_adder_tree.sv
// Reduces LANES lane magnitudes to one sum with a pairwise tree.
// Lane count is padded to a power of two with zero leaves.
module sad_adder_tree #(
    parameter int LANES = 16,
    parameter int PIX_W = 8,
    parameter int SUM_W = 12
) (
    input  logic [LANES*PIX_W-1:0] mags,
    output logic [SUM_W-1:0]       sum
);

    localparam int LVLS = (LANES < 2) ? 1 : $clog2(LANES);
    localparam int NPAD = 1 << LVLS;

    logic [SUM_W-1:0] node [NPAD];

    // Load the leaves, then fold by doubling strides; node[0] ends as the total.
    always_comb begin
        for (int i = 0; i < NPAD; i++) begin
            if (i < LANES) begin
                node[i] = SUM_W'(mags[i*PIX_W +: PIX_W]);
            end else begin
                node[i] = '0;
            end
        end
        for (int s = 1; s < NPAD; s = s * 2) begin
            for (int j = 0; j + s < NPAD; j = j + 2 * s) begin
                node[j] = node[j] + node[j+s];
            end
        end
        sum = node[0];
    end

endmodule

// File: rtl/sad_row_ctrl.sv
// Row sequencer: counts accepted rows, owns ready and the done pulse.
// A start always wins over a row offered in the same cycle.
module sad_row_ctrl #(
    parameter int ROWS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic row_valid,
    output logic row_ready,
    output logic accept,
    output logic done
);

    localparam int CNT_W = (ROWS < 2) ? 1 : $clog2(ROWS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROWS - 1);

    logic             busy;
    logic [CNT_W-1:0] count;

    assign row_ready = busy;
    assign accept    = busy && row_valid && !start;

    // Track busy state, row index and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            count <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                count <= '0;
            end else if (accept) begin
                if (count == LAST) begin
                    busy  <= 1'b0;
                    count <= '0;
                    done  <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // R5: done lasts a single cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion leaves the engine not ready
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !row_ready);

endmodule

// File: rtl/sad_accum.sv
// Block accumulator: cleared by start, adds one row sum per accepted row.
// Width is chosen by the parent so the worst case cannot wrap.
module sad_accum #(
    parameter int SUM_W = 12,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [SUM_W-1:0] row_sum,
    output logic [ACC_W-1:0] acc
);

    // Clear on start, otherwise add the row sum on each accepted row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (accept) begin
            acc <= acc + ACC_W'(row_sum);
        end
    end

    // R7: an accepted row never makes the total smaller (no wrap)
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear) |=> (acc >= $past(acc)));

endmodule

// File: rtl/sad_row_engine.sv
// Row-parallel SAD engine: 16 lanes of subtract-magnitude feed an adder
// tree whose sum is added to the block total in the accepting cycle.
// Assumes start_i is synchronous and row data is defined when valid.
module sad_row_engine
    import sad_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int PIX_W = DEF_PIX_W,
    parameter int ROWS  = DEF_ROWS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start_i,
    input  logic                                    row_valid_i,
    output logic                                    row_ready_o,
    input  logic [LANES*PIX_W-1:0]                  row_a_i,
    input  logic [LANES*PIX_W-1:0]                  row_b_i,
    output logic [acc_width(ROWS,LANES,PIX_W)-1:0]  sad_o,
    output logic                                    done_o
);

    localparam int SUM_W = row_sum_width(LANES, PIX_W);
    localparam int ACC_W = acc_width(ROWS, LANES, PIX_W);

    logic [LANES*PIX_W-1:0] mags;
    logic [SUM_W-1:0]       row_sum;
    logic                   accept;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sad_lane_absdiff #(.PIX_W(PIX_W)) u_lane (
            .pix_a (row_a_i[g*PIX_W +: PIX_W]),
            .pix_b (row_b_i[g*PIX_W +: PIX_W]),
            .mag   (mags[g*PIX_W +: PIX_W])
        );
    end

    sad_adder_tree #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_tree (
        .mags (mags),
        .sum  (row_sum)
    );

    sad_row_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .row_valid (row_valid_i),
        .row_ready (row_ready_o),
        .accept    (accept),
        .done      (done_o)
    );

    sad_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_i),
        .accept  (accept),
        .row_sum (row_sum),
        .acc     (sad_o)
    );

    // R2: a start leaves a zero total and an open handshake
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sad_o == '0) && row_ready_o);

    // R6: while idle and not restarted, the total holds
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_ready_o && !start_i) |=> $stable(sad_o));

    // R3: without valid the total holds
    p_no_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_valid_i && !start_i) |=> $stable(sad_o));

endmodule

// File: tb/tb_sad_row_engine.sv
module tb_sad_row_engine;

    localparam int LANES = 16;
    localparam int PW    = 8;
    localparam int W     = LANES * PW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         row_valid_i = 1'b0;
    logic         row_ready_o;
    logic [W-1:0] row_a_i = '0;
    logic [W-1:0] row_b_i = '0;
    logic [15:0]  sad_o;
    logic         done_o;

    int total = 0;
    int bad   = 0;
    int exp_sad = 0;

    always #4 clk = ~clk;

    sad_row_engine dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .row_valid_i (row_valid_i),
        .row_ready_o (row_ready_o),
        .row_a_i     (row_a_i),
        .row_b_i     (row_b_i),
        .sad_o       (sad_o),
        .done_o      (done_o)
    );

    function automatic int row_sad(input logic [W-1:0] a, input logic [W-1:0] b);
        int s = 0;
        for (int i = 0; i < LANES; i++) begin
            int x = int'(a[i*PW +: PW]);
            int y = int'(b[i*PW +: PW]);
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    function automatic logic [W-1:0] rand_row();
        logic [W-1:0] r;
        for (int k = 0; k < W / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_start(input bit with_row);
        start_i = 1'b1;
        row_valid_i = with_row;
        row_a_i = '1;
        row_b_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        row_valid_i = 1'b0;
        exp_sad = 0;
        check(sad_o == 16'd0, "R2 cleared", int'(sad_o), 0);
        check(row_ready_o == 1'b1, "R2 ready", int'(row_ready_o), 1);
        if (with_row) check(sad_o == 16'd0, "R8 row with start dropped", int'(sad_o), 0);
    endtask

    task automatic send_row(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit last, input int gaps);
        for (int g = 0; g < gaps; g++) begin
            row_valid_i = 1'b0;
            row_a_i = rand_row();
            row_b_i = rand_row();
            @(negedge clk);
            check(int'(sad_o) == exp_sad, "R3 gap holds", int'(sad_o), exp_sad);
        end
        row_valid_i = 1'b1;
        row_a_i = a;
        row_b_i = b;
        @(negedge clk);
        row_valid_i = 1'b0;
        exp_sad += row_sad(a, b);
        check(int'(sad_o) == exp_sad, "R4 row added", int'(sad_o), exp_sad);
        check(done_o == last, "R5 done timing", int'(done_o), int'(last));
        if (last) check(row_ready_o == 1'b0, "R5 not ready", int'(row_ready_o), 0);
    endtask

    task automatic after_done();
        @(negedge clk);
        check(done_o == 1'b0, "R5 done falls", int'(done_o), 0);
        for (int k = 0; k < 3; k++) begin
            row_valid_i = 1'b1;
            row_a_i = rand_row();
            row_b_i = rand_row();
            @(negedge clk);
            check(int'(sad_o) == exp_sad, "R6 result held", int'(sad_o), exp_sad);
        end
        row_valid_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pa, pb;
        void'($urandom(32'h5AD0_0016));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sad_o == 16'd0, "R1 sad", int'(sad_o), 0);
        check(done_o == 1'b0, "R1 done", int'(done_o), 0);
        check(row_ready_o == 1'b0, "R1 ready", int'(row_ready_o), 0);

        // R6/R3: rows offered before any start are not consumed
        row_valid_i = 1'b1;
        row_a_i = '1;
        @(negedge clk);
        row_valid_i = 1'b0;
        check(sad_o == 16'd0, "R3 idle row ignored", int'(sad_o), 0);

        // random blocks with random gaps
        for (int blk = 0; blk < 6; blk++) begin
            do_start(1'b0);
            for (int r = 0; r < 16; r++)
                send_row(rand_row(), rand_row(), r == 15, int'($urandom_range(0, 2)));
            after_done();
        end

        // identical blocks give zero
        do_start(1'b0);
        for (int r = 0; r < 16; r++) begin
            pa = rand_row();
            send_row(pa, pa, r == 15, 0);
        end
        check(sad_o == 16'd0, "R4 equal blocks", int'(sad_o), 0);
        after_done();

        // worst case: 255 against 0 in every lane
        do_start(1'b0);
        for (int r = 0; r < 16; r++)
            send_row((r % 2 == 0) ? '1 : '0, (r % 2 == 0) ? '0 : '1, r == 15, 0);
        check(sad_o == 16'd65280, "R7 worst case", int'(sad_o), 65280);
        after_done();

        // alternating lane polarity, checks per-lane placement
        do_start(1'b0);
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < LANES; i++) begin
                pa[i*PW +: PW] = (i % 2 == 0) ? 8'(i * 9 + r) : 8'd3;
                pb[i*PW +: PW] = (i % 2 == 0) ? 8'd1 : 8'(200 - i - r);
            end
            send_row(pa, pb, r == 15, 1);
        end
        after_done();

        // restart mid-block with a row offered in the start cycle
        do_start(1'b0);
        for (int r = 0; r < 5; r++) send_row(rand_row(), rand_row(), 1'b0, 0);
        do_start(1'b1);
        for (int r = 0; r < 16; r++) send_row(rand_row(), rand_row(), r == 15, 0);
        check(done_o == 1'b1, "R8 full count after restart", int'(done_o), 1);
        after_done();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule